// File: doc/BRIEF.md
# Latency-Addressed Sample Pipeline with Hold Flags

This block is a digital model of a front-end sample pipeline. Every clock cycle it stores the sample on its input into the next free slot of a circular buffer with 192 slots. When a trigger arrives, it selects the slot that was written a programmable number of cycles earlier, the look-back latency. It marks that slot as held and queues the slot for readout. The write pointer steps over held slots, so a selected sample stays in place until it has been read out. Writing never stops, so triggers cause no dead time.

A downstream consumer drains held slots in the order of their triggers through a valid/ready port. Reading a slot releases it for writing again. A small register write port loads the look-back latency and a 6-bit operating-mode word. A latency above 160 is refused and flagged. A trigger that finds the hold capacity used up is dropped and flagged.

Top module: `lat_pipe_buf`

## Requirements
- R1: While reset is asserted and directly after it: `rd_valid_o`=0, `latency_o`=132, `mode_o`=0, `lat_err_o`=0 and `ovf_err_o`=0.
- R2: Each clock writes `samp_i` into a free slot. A trigger accepted at clock edge k with latency L selects the slot written at edge k-L. L=0 selects the slot written at edge k itself. The data later presented for that trigger equals the sample that was on `samp_i` L edges before the trigger edge.
- R3: A register write with `cfg_sel_i`=0 loads the latency when `cfg_wdata_i` is 0 to 160 and clears `lat_err_o`. A value of 161 or more is refused: the previous latency stays and `lat_err_o` is set. Either effect is visible from the cycle after the write edge.
- R4: A register write with `cfg_sel_i`=1 stores `cfg_wdata_i[5:0]` into `mode_o` and leaves the latency unchanged.
- R5: A held slot is never written. Its sample is still delivered intact after more than 192 further clocks without readout.
- R6: `rd_valid_o` is high exactly while at least one accepted trigger is pending. Pending entries are presented in trigger order. A pop happens on a clock edge where `rd_valid_o` and `rd_ready_i` are both high, and it releases the slot.
- R7: A trigger that arrives while 8 entries are pending and no pop happens in the same cycle is dropped. It sets `ovf_err_o`, which stays set until reset. The 8 pending entries are unaffected.
- R8: A trigger and a pop on the same edge both take effect, including when 8 entries are pending. In that case the trigger is accepted and `ovf_err_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one slot write per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_i | input | 8 | Sample to be stored this cycle |
| trig_i | input | 1 | Trigger, one per high cycle |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 latency, 1 mode |
| cfg_wdata_i | input | 8 | Register write value |
| rd_ready_i | input | 1 | Consumer accepts the presented entry |
| rd_valid_o | output | 1 | A held entry is presented |
| rd_data_o | output | 8 | Sample of the oldest pending entry |
| rd_slot_o | output | 8 | Slot index of the oldest pending entry |
| latency_o | output | 8 | Current look-back latency in cycles |
| mode_o | output | 6 | Current operating-mode word |
| lat_err_o | output | 1 | Last latency write was refused |
| ovf_err_o | output | 1 | A trigger was dropped for lack of hold capacity |

## Verification
The two functions that can meet in one cycle are a new trigger, which holds a slot and pushes it, and a readout pop, which releases a slot. The bench drives `trig_i` and `rd_ready_i` high in the same cycle twice: once with a single entry pending, and once with the queue filled to capacity. A correct block keeps the new trigger in both cases. The bench judges this by checking that `ovf_err_o` stays low and by draining the queue afterwards. Every drained sample must match, in trigger order, the value the bench itself drove the chosen number of cycles before each trigger.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

    localparam int PB_DEPTH   = 192;
    localparam int PB_DATA_W  = 8;
    localparam int PB_LAT_MAX = 160;
    localparam int PB_LAT_RST = 132;
    localparam int PB_QDEPTH  = 8;
    localparam int PB_MODE_W  = 6;
    localparam int PB_CFG_W   = 8;

    typedef enum logic {
        CFG_LATENCY = 1'b0,
        CFG_MODE    = 1'b1
    } cfg_sel_e;

endpackage

// File: rtl/pbuf_cfg.sv
module pbuf_cfg
    import pbuf_pkg::*;
#(
    parameter int LAT_MAX = PB_LAT_MAX,
    parameter int LAT_RST = PB_LAT_RST,
    parameter int MODE_W  = PB_MODE_W,
    parameter int CFG_W   = PB_CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              sel_i,
    input  logic [CFG_W-1:0]  wdata_i,
    output logic [CFG_W-1:0]  lat_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              err_o
);

    localparam logic [CFG_W-1:0] LAT_LIM = CFG_W'(LAT_MAX);

    typedef struct packed {
        logic [CFG_W-1:0]  lat;
        logic [MODE_W-1:0] mode;
        logic              err;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            if (sel_i == CFG_LATENCY) begin
                if (wdata_i > LAT_LIM) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.lat = wdata_i;
                    st_d.err = 1'b0;
                end
            end else begin
                st_d.mode = wdata_i[MODE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat  <= CFG_W'(LAT_RST);
            st_q.mode <= '0;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_o  = st_q.lat;
    assign mode_o = st_q.mode;
    assign err_o  = st_q.err;

    AST_LAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lat <= LAT_LIM); // R3
    AST_LAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == CFG_LATENCY && wdata_i > LAT_LIM) |=> ($stable(st_q.lat) && st_q.err)); // R3
    AST_MODE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == CFG_MODE) |=> $stable(st_q.lat)); // R4

endmodule

// File: rtl/pbuf_wptr.sv
module pbuf_wptr
    import pbuf_pkg::*;
#(
    parameter int DEPTH = PB_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [AW-1:0]    set_idx_i,
    input  logic             clr_i,
    input  logic [AW-1:0]    clr_idx_i,
    output logic [AW-1:0]    wptr_o,
    output logic [DEPTH-1:0] held_o
);

    typedef struct packed {
        logic [DEPTH-1:0] held;
        logic [AW-1:0]    wptr;
    } wp_t;

    wp_t st_d, st_q;

    always_comb begin
        int cand;
        logic [AW-1:0] nxt;
        st_d = st_q;
        if (clr_i) st_d.held[clr_idx_i] = 1'b0;
        if (set_i) st_d.held[set_idx_i] = 1'b1;
        nxt = st_q.wptr;
        for (int i = DEPTH - 1; i >= 1; i--) begin
            cand = int'(st_q.wptr) + i;
            if (cand >= DEPTH) cand = cand - DEPTH;
            if (!st_d.held[AW'(cand)]) nxt = AW'(cand);
        end
        st_d.wptr = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.held <= '0;
            st_q.wptr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wptr_o = st_q.wptr;
    assign held_o = st_q.held;

    AST_WRITE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.held[st_q.wptr]); // R5
    AST_RELEASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> st_q.held[clr_idx_i]); // R6

endmodule

// File: rtl/pbuf_rdq.sv
module pbuf_rdq
    import pbuf_pkg::*;
#(
    parameter int QDEPTH = PB_QDEPTH,
    parameter int AW     = 8,
    localparam int QAW   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
    localparam int CW    = $clog2(QDEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [AW-1:0] push_idx_i,
    input  logic          pop_i,
    output logic          valid_o,
    output logic          full_o,
    output logic [AW-1:0] head_idx_o
);

    typedef struct packed {
        logic [QDEPTH-1:0][AW-1:0] ent;
        logic [QAW-1:0]            head;
        logic [QAW-1:0]            tail;
        logic [CW-1:0]             cnt;
    } rq_t;

    rq_t st_d, st_q;

    function automatic logic [QAW-1:0] step(input logic [QAW-1:0] x);
        return (int'(x) == QDEPTH - 1) ? '0 : x + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (pop_i) st_d.head = step(st_q.head);
        if (push_i) begin
            st_d.ent[st_q.tail] = push_idx_i;
            st_d.tail = step(st_q.tail);
        end
        case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ent  <= '0;
            st_q.head <= '0;
            st_q.tail <= '0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o    = (st_q.cnt != '0);
    assign full_o     = (st_q.cnt == CW'(QDEPTH));
    assign head_idx_o = st_q.ent[st_q.head];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && full_o && !pop_i)); // R7
    AST_POP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (st_q.cnt != '0)); // R6

endmodule

// File: rtl/lat_pipe_buf.sv
module lat_pipe_buf
    import pbuf_pkg::*;
#(
    parameter int DEPTH   = PB_DEPTH,
    parameter int DATA_W  = PB_DATA_W,
    parameter int LAT_MAX = PB_LAT_MAX,
    parameter int LAT_RST = PB_LAT_RST,
    parameter int QDEPTH  = PB_QDEPTH,
    parameter int MODE_W  = PB_MODE_W,
    parameter int CFG_W   = PB_CFG_W,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] samp_i,
    input  logic              trig_i,
    input  logic              cfg_we_i,
    input  logic              cfg_sel_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    input  logic              rd_ready_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [AW-1:0]     rd_slot_o,
    output logic [CFG_W-1:0]  latency_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              lat_err_o,
    output logic              ovf_err_o
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DEPTH-1:0][AW-1:0]     hist;
        logic [AW-1:0]                tnow;
        logic                         ovf;
    } top_t;

    top_t st_d, st_q;

    logic [CFG_W-1:0]  lat;
    logic [AW-1:0]     wptr;
    logic [DEPTH-1:0]  held;
    logic              q_valid, q_full;
    logic [AW-1:0]     q_head;
    logic              pop, accept;
    logic [AW-1:0]     sel_slot;

    pbuf_cfg #(
        .LAT_MAX (LAT_MAX),
        .LAT_RST (LAT_RST),
        .MODE_W  (MODE_W),
        .CFG_W   (CFG_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .sel_i   (cfg_sel_i),
        .wdata_i (cfg_wdata_i),
        .lat_o   (lat),
        .mode_o  (mode_o),
        .err_o   (lat_err_o)
    );

    pbuf_wptr #(
        .DEPTH (DEPTH)
    ) u_wptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (accept),
        .set_idx_i (sel_slot),
        .clr_i     (pop),
        .clr_idx_i (q_head),
        .wptr_o    (wptr),
        .held_o    (held)
    );

    pbuf_rdq #(
        .QDEPTH (QDEPTH),
        .AW     (AW)
    ) u_rdq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (accept),
        .push_idx_i (sel_slot),
        .pop_i      (pop),
        .valid_o    (q_valid),
        .full_o     (q_full),
        .head_idx_o (q_head)
    );

    always_comb begin
        int look;
        pop    = rd_ready_i && q_valid;
        accept = trig_i && (!q_full || pop);
        look   = int'(st_q.tnow) - int'(lat);
        if (look < 0) look = look + DEPTH;
        sel_slot = (lat == '0) ? wptr : st_q.hist[AW'(look)];

        st_d = st_q;
        st_d.mem[wptr]      = samp_i;
        st_d.hist[st_q.tnow] = wptr;
        st_d.tnow = (st_q.tnow == AW'(DEPTH - 1)) ? '0 : st_q.tnow + 1'b1;
        if (trig_i && !accept) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mem  <= '0;
            st_q.hist <= '0;
            st_q.tnow <= '0;
            st_q.ovf  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid_o = q_valid;
    assign rd_data_o  = st_q.mem[q_head];
    assign rd_slot_o  = q_head;
    assign latency_o  = lat;
    assign ovf_err_o  = st_q.ovf;

    AST_SEL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !held[sel_slot]); // R2
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf); // R7
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> held[q_head]); // R5
    AST_BOTH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && pop) |=> !$rose(st_q.ovf)); // R8

endmodule

// File: tb/lat_pipe_buf_test.sv
`timescale 1ns/1ps
module lat_pipe_buf_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] samp_i = '0;
    logic       trig_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic       cfg_sel_i = 1'b0;
    logic [7:0] cfg_wdata_i = '0;
    logic       rd_ready_i = 1'b0;
    logic       rd_valid_o;
    logic [7:0] rd_data_o;
    logic [7:0] rd_slot_o;
    logic [7:0] latency_o;
    logic [5:0] mode_o;
    logic       lat_err_o;
    logic       ovf_err_o;

    int  cyc = 0;
    int  nchk = 0;
    int  nerr = 0;
    bit  done = 0;
    int  fc[9];

    localparam int NV = 6;
    localparam int V_LAT[NV] = '{1, 5, 132, 160, 0, 77};
    localparam int V_GAP[NV] = '{3, 0, 10, 1, 2, 40};

    lat_pipe_buf uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .samp_i      (samp_i),
        .trig_i      (trig_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_sel_i   (cfg_sel_i),
        .cfg_wdata_i (cfg_wdata_i),
        .rd_ready_i  (rd_ready_i),
        .rd_valid_o  (rd_valid_o),
        .rd_data_o   (rd_data_o),
        .rd_slot_o   (rd_slot_o),
        .latency_o   (latency_o),
        .mode_o      (mode_o),
        .lat_err_o   (lat_err_o),
        .ovf_err_o   (ovf_err_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int fval(int c);
        return (c * 7 + 3) & 255;
    endfunction

    always @(negedge clk) samp_i <= 8'(fval(cyc));

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(logic sel, logic [7:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1;
        cfg_sel_i = sel;
        cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic fire(output int c);
        @(negedge clk);
        trig_i = 1'b1;
        c = cyc;
        @(negedge clk);
        trig_i = 1'b0;
    endtask

    task automatic take();
        rd_ready_i = 1'b1;
        @(negedge clk);
        rd_ready_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int c, ca, cb, cn;
        idle(4);
        // R1 reset state
        chk("R1 valid in reset", rd_valid_o, 0);
        chk("R1 latency in reset", latency_o, 132);
        chk("R1 mode in reset", mode_o, 0);
        chk("R1 lat_err in reset", lat_err_o, 0);
        chk("R1 ovf_err in reset", ovf_err_o, 0);
        rst_n = 1'b1;
        idle(1);
        chk("R1 latency after reset", latency_o, 132);
        chk("R1 valid after reset", rd_valid_o, 0);
        idle(200);

        // table of latencies and gaps
        for (int v = 0; v < NV; v++) begin
            cfg_write(1'b0, 8'(V_LAT[v]));
            chk("R3 latency load", latency_o, V_LAT[v]);
            chk("R3 lat_err after accepted", lat_err_o, 0);
            idle(V_GAP[v]);
            fire(c);
            chk("R6 valid after trigger", rd_valid_o, 1);
            chk("R2 selected sample", rd_data_o, fval(c - V_LAT[v]));
            take();
            chk("R6 empty after pop", rd_valid_o, 0);
        end

        // R5 held slot survives more than a full ring of writes
        cfg_write(1'b0, 8'd10);
        fire(c);
        idle(400);
        chk("R5 held sample intact", rd_data_o, fval(c - 10));
        chk("R5 still pending", rd_valid_o, 1);
        take();

        // R6 trigger order
        cfg_write(1'b0, 8'd20);
        fire(fc[0]);
        idle(2);
        fire(fc[1]);
        idle(4);
        fire(fc[2]);
        for (int i = 0; i < 3; i++) begin
            chk("R6 in-order valid", rd_valid_o, 1);
            chk("R6 in-order data", rd_data_o, fval(fc[i] - 20));
            take();
        end
        chk("R6 drained", rd_valid_o, 0);

        // R8 trigger and pop in the same cycle, one pending
        cfg_write(1'b0, 8'd30);
        fire(ca);
        trig_i = 1'b1;
        rd_ready_i = 1'b1;
        cb = cyc;
        @(negedge clk);
        trig_i = 1'b0;
        rd_ready_i = 1'b0;
        chk("R8 new entry kept", rd_valid_o, 1);
        chk("R8 new entry data", rd_data_o, fval(cb - 30));
        take();
        chk("R8 single entry left", rd_valid_o, 0);

        // R8 with a full queue
        cfg_write(1'b0, 8'd3);
        @(negedge clk);
        trig_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            fc[i] = cyc;
            @(negedge clk);
        end
        rd_ready_i = 1'b1;
        cn = cyc;
        @(negedge clk);
        trig_i = 1'b0;
        rd_ready_i = 1'b0;
        chk("R8 no overflow on trigger with pop", ovf_err_o, 0);
        for (int i = 1; i < 8; i++) begin
            chk("R8 full-queue order", rd_data_o, fval(fc[i] - 3));
            take();
        end
        chk("R8 trigger accepted at full", rd_data_o, fval(cn - 3));
        take();
        chk("R8 queue empty", rd_valid_o, 0);

        // R7 overflow drop
        cfg_write(1'b0, 8'd4);
        @(negedge clk);
        trig_i = 1'b1;
        for (int i = 0; i < 9; i++) begin
            fc[i] = cyc;
            @(negedge clk);
        end
        trig_i = 1'b0;
        chk("R7 ovf_err set", ovf_err_o, 1);
        for (int i = 0; i < 8; i++) begin
            chk("R7 pending entries intact", rd_data_o, fval(fc[i] - 4));
            take();
        end
        chk("R7 ninth trigger dropped", rd_valid_o, 0);
        chk("R7 ovf_err sticky", ovf_err_o, 1);

        // R3 refused latency writes
        cfg_write(1'b0, 8'd161);
        chk("R3 161 refused keeps latency", latency_o, 4);
        chk("R3 161 sets lat_err", lat_err_o, 1);
        cfg_write(1'b0, 8'd255);
        chk("R3 255 refused keeps latency", latency_o, 4);
        chk("R3 lat_err held", lat_err_o, 1);
        cfg_write(1'b0, 8'd160);
        chk("R3 160 accepted", latency_o, 160);
        chk("R3 lat_err cleared", lat_err_o, 0);

        // R4 mode register
        cfg_write(1'b1, 8'hE5);
        chk("R4 mode low bits", mode_o, 37);
        chk("R4 latency untouched", latency_o, 160);
        cfg_write(1'b1, 8'h3F);
        chk("R4 mode all ones", mode_o, 63);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule